// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine moves frames from host memory to a MAC. The host keeps a ring of transmit descriptors in memory. Each descriptor is four 16-bit words. Once started, the engine sleeps until it is woken by either a demand pulse or a periodic poll tick. It then reads the flag word of the current descriptor.

If the ownership bit shows that the hardware owns the entry, the engine does the following:
- fetches the buffer address and the length,
- streams the buffer to the MAC one byte at a time over a valid/ready interface,
- waits for the MAC to report the outcome.

It then writes a status word back into the descriptor and, as the last step, rewrites the flag word. That final write hands the entry back to the host and carries a summary of errors and retries. A one-cycle completion pulse follows. The engine then moves straight on to the next entry, wrapping at the ring size, and keeps going until it meets an entry the host still owns.

Memory is a single word port: one request per cycle, read data returned the cycle after a read. Descriptor `i` begins at word `ring_base + 4*i`, and `ring_base` must be a multiple of four.

The descriptor word offsets are:

| Offset | Contents |
|---|---|
| 0 | Buffer byte address bits 15:0 |
| 1 | Flag byte in bits 15:8, buffer byte address bits 23:16 in bits 7:0 |
| 2 | Length word |
| 3 | Status word |

The buffer is byte-addressed. Byte `b` lives in word `b>>1`: an even byte sits in bits 15:8 and an odd byte in bits 7:0.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset, and while idle, `tx_valid`, `mem_req` and `tint` are 0. In idle, `cmd_demand` and `poll_tick` cause no memory access; only `cmd_start` leaves idle.
- R2: When running and asleep, a `cmd_demand` or `poll_tick` pulse makes the engine issue, in the next cycle, a read of word `ring_base + 4*idx + 1`, where `idx` is the current entry.
- R3: If the flag word read back has bit 15 (ownership) clear, the engine performs no write and sends no byte. It goes back to sleep with the same `idx`, so the next wake reads the same word again.
- R4: The byte count is the low 12 bits of the two's complement of the length word. A result of 0 means 4096 bytes.
- R5: Bytes go out in increasing byte-address order from the 24-bit buffer address, using the even-high/odd-low packing. `tx_last` is 1 only on the final byte.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` stay unchanged in the next cycle.
- R7: After the MAC's `mac_done`, the engine writes the status word to offset 3, laid out as:
  - bit 15: ownership missing end-of-frame (see R10)
  - bit 14: underflow
  - bit 13: 0
  - bit 12: late collision
  - bit 11: carrier lost
  - bit 10: retry limit
  - bits 9:0: the reflectometry count
- R8: In the cycle after the status write, the engine writes offset 1. That word carries the buffer address bits 23:16 in bits 7:0 and the flag byte in bits 15:8, with these bits:
  - bit 15 (ownership): cleared
  - bit 14: error summary
  - bit 12: more than one retry
  - bit 11: exactly one retry
  - bit 10: deferred
  - bits 13, 9 and 8 (start and end of frame): unchanged from the fetched word
- R9: Bit 14 of the written flag word is 1 exactly when any of status bits 15, 14, 12, 11 or 10 is 1. `mac_retries` of 1 sets bit 11 only; a value of 2 or 3 sets bit 12 only.
- R10: If the fetched flag word has bit 8 (end of frame) clear, the buffer is still sent with `tx_last` on its final byte, and status bit 15 is set.
- R11: `tint` is a single-cycle pulse in the cycle right after the flag write, once per completed entry.
- R12: After each completion, `idx` advances modulo `2^ring_len_word[15:13]`. The next entry is examined at once, with no new wake.
- R13: `cmd_stop` has priority in any state. In the next cycle `tx_valid`, `mem_req` and `tint` are 0, nothing further is written, and `idx` returns to 0, so the next start begins at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Leave idle; latches ring base and size |
| cmd_stop | input | 1 | Return to idle, entry index to 0 |
| cmd_demand | input | 1 | Poll the current entry now |
| poll_tick | input | 1 | Periodic poll request |
| ring_base | input | AW | Word address of descriptor 0 |
| ring_len_word | input | 16 | Bits 15:13 give log2 of the ring size |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| tx_valid | output | 1 | Byte offered to the MAC |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the buffer |
| tx_ready | input | 1 | MAC accepts the byte |
| mac_done | input | 1 | MAC outcome valid (pulse) |
| mac_retries | input | 2 | Number of retries, saturating at 3 |
| mac_deferred | input | 1 | Transmission was deferred |
| mac_rtry | input | 1 | Gave up after the retry limit |
| mac_lcar | input | 1 | Carrier lost |
| mac_lcol | input | 1 | Late collision |
| mac_uflo | input | 1 | Underflow |
| mac_tdr | input | 10 | Reflectometry count |
| tint | output | 1 | Entry completed (pulse) |

## Verification
The main path is tried with several buffer shapes:
- An even-aligned buffer with the MAC always ready, and an odd-aligned buffer under a pseudo-random ready stall. Together these separate byte packing errors from handshake errors.
- A one-byte buffer without end-of-frame, and a length word of 0xF000 (4096 bytes). These pin the length decode at both ends.

For write-back, the MAC outcomes are varied so that one retry, more than one retry, deferral alone and several error bits each produce a distinct flag/status pair. This shows whether the error summary tracks only the five error bits.

Finally, a two-entry ring processed on one demand checks the chaining and the wrap, and a stop in the middle of a long buffer checks that nothing is written afterwards and that the restart reads entry 0.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int unsigned RING_LOG_W = 3;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned CNT_W      = 13;

  localparam logic [1:0] OFS_ADDR_LO = 2'd0;
  localparam logic [1:0] OFS_FLAG    = 2'd1;
  localparam logic [1:0] OFS_LEN     = 2'd2;
  localparam logic [1:0] OFS_STAT    = 2'd3;

  localparam int unsigned FB_OWN  = 7;
  localparam int unsigned FB_ERR  = 6;
  localparam int unsigned FB_MORE = 4;
  localparam int unsigned FB_ONE  = 3;
  localparam int unsigned FB_DEF  = 2;
  localparam int unsigned FB_ENP  = 0;

  // status bits that feed the error summary
  localparam logic [15:0] STAT_ERR_MASK = 16'hDC00;

  typedef struct packed {
    logic [1:0] retries;
    logic       deferred;
    logic       rtry;
    logic       lcar;
    logic       lcol;
    logic       uflo;
    logic [9:0] tdr;
  } mac_stat_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_RFLG, ST_CFLG, ST_RALO, ST_ALO, ST_LEN,
    ST_BRD, ST_BLAT, ST_BOUT, ST_MACW, ST_WSTAT, ST_WFLG
  } eng_state_e;

  // negated length with forced high bits -> byte count, 0 meaning 4096
  function automatic logic [CNT_W-1:0] len_to_count(input logic [15:0] len_word);
    logic [15:0] pos;
    pos = ~len_word + 16'd1;
    return {(pos[11:0] == 12'd0), pos[11:0]};
  endfunction

  function automatic logic [15:0] pack_status(input mac_stat_t s, input logic buff);
    return {buff, s.uflo, 1'b0, s.lcol, s.lcar, s.rtry, s.tdr};
  endfunction

  function automatic logic [7:0] update_flag(input logic [7:0] f, input logic [15:0] st,
                                             input logic [1:0] retries, input logic deferred);
    logic [7:0] r;
    r          = f;
    r[FB_OWN]  = 1'b0;
    r[FB_ERR]  = |(st & STAT_ERR_MASK);
    r[FB_MORE] = (retries >= 2'd2);
    r[FB_ONE]  = (retries == 2'd1);
    r[FB_DEF]  = deferred;
    return r;
  endfunction

  function automatic logic [7:0] byte_pick(input logic [15:0] word, input logic odd);
    return odd ? word[7:0] : word[15:8];
  endfunction

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int unsigned LOG_W = 3,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [LOG_W-1:0] ring_log,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W:0]   ring_size
);

  logic [IDX_W-1:0] mask;

  for (genvar g = 0; g < IDX_W; g++) begin : g_mask
    assign mask[g] = (ring_log > LOG_W'(g));
  end

  assign ring_size = (IDX_W+1)'(1) << ring_log;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (advance) idx <= (idx + 1'b1) & mask;
  end

endmodule

// File: rtl/txd_byte_walker.sv
module txd_byte_walker #(
  parameter int unsigned BAW = 24,
  parameter int unsigned CW  = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [BAW-1:0] start_addr,
  input  logic [CW-1:0]  count,
  input  logic           step,
  output logic [BAW-1:0] cur_addr,
  output logic           final_byte
);

  logic [CW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
    end else if (load) begin
      cur_addr  <= start_addr;
      remaining <= count;
    end else if (step) begin
      cur_addr  <= cur_addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  assign final_byte = (remaining == CW'(1));

endmodule

// File: rtl/txd_wb_format.sv
module txd_wb_format
  import txd_pkg::*;
(
  input  logic [7:0]  flag_in,
  input  mac_stat_t   st,
  output logic [15:0] stat_word,
  output logic [7:0]  flag_out
);

  assign stat_word = pack_status(st, ~flag_in[FB_ENP]);
  assign flag_out  = update_flag(flag_in, stat_word, st.retries, st.deferred);

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int unsigned BAW = 24,
  parameter int unsigned AW  = BAW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_demand,
  input  logic          poll_tick,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   ring_len_word,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          mac_done,
  input  logic [1:0]    mac_retries,
  input  logic          mac_deferred,
  input  logic          mac_rtry,
  input  logic          mac_lcar,
  input  logic          mac_lcol,
  input  logic          mac_uflo,
  input  logic [9:0]    mac_tdr,
  output logic          tint
);

  eng_state_e st_q, st_d;

  logic [AW-1:0]         base_q;
  logic [RING_LOG_W-1:0] log_q;
  logic [7:0]            flag_q;
  logic [7:0]            ahi_q;
  logic [15:0]           alo_q;
  logic [7:0]            byte_q;
  logic                  last_q;
  logic                  tint_q;
  mac_stat_t             mstat_q;

  logic [IDX_W-1:0]      idx;
  logic [IDX_W:0]        ring_size;
  logic [AW-1:0]         desc_addr;
  logic [BAW-1:0]        cur_addr;
  logic                  final_byte;
  logic [15:0]           stat_word;
  logic [7:0]            flag_out;

  // named events for the checker
  logic ev_stat_wr, ev_flag_wr, ev_advance, ev_step, eng_idle;
  logic len_word_unused;

  assign len_word_unused = ^ring_len_word[12:0];

  assign eng_idle   = (st_q == ST_IDLE);
  assign ev_stat_wr = (st_q == ST_WSTAT);
  assign ev_flag_wr = (st_q == ST_WFLG);
  assign ev_advance = ev_flag_wr && !cmd_stop;
  assign ev_step    = (st_q == ST_BOUT) && tx_ready && !cmd_stop;

  txd_ring_ptr #(.LOG_W(RING_LOG_W), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd_stop),
    .advance   (ev_advance),
    .ring_log  (log_q),
    .idx       (idx),
    .ring_size (ring_size)
  );

  txd_byte_walker #(.BAW(BAW), .CW(CNT_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (st_q == ST_LEN),
    .start_addr (BAW'({ahi_q, alo_q})),
    .count      (len_to_count(mem_rdata)),
    .step       (ev_step),
    .cur_addr   (cur_addr),
    .final_byte (final_byte)
  );

  txd_wb_format u_fmt (
    .flag_in   (flag_q),
    .st        (mstat_q),
    .stat_word (stat_word),
    .flag_out  (flag_out)
  );

  assign desc_addr = base_q + AW'({idx, 2'b00});

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (cmd_start) st_d = ST_WAIT;
      ST_WAIT:  if (cmd_demand || poll_tick) st_d = ST_RFLG;
      ST_RFLG:  st_d = ST_CFLG;
      ST_CFLG:  st_d = mem_rdata[8 + FB_OWN] ? ST_RALO : ST_WAIT;
      ST_RALO:  st_d = ST_ALO;
      ST_ALO:   st_d = ST_LEN;
      ST_LEN:   st_d = ST_BRD;
      ST_BRD:   st_d = ST_BLAT;
      ST_BLAT:  st_d = ST_BOUT;
      ST_BOUT:  if (tx_ready) st_d = last_q ? ST_MACW : ST_BRD;
      ST_MACW:  if (mac_done) st_d = ST_WSTAT;
      ST_WSTAT: st_d = ST_WFLG;
      ST_WFLG:  st_d = ST_RFLG;
      default:  st_d = ST_IDLE;
    endcase
    if (cmd_stop) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      log_q   <= '0;
      flag_q  <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      tint_q  <= 1'b0;
      mstat_q <= '0;
    end else begin
      st_q   <= st_d;
      tint_q <= ev_advance;
      if (eng_idle && cmd_start) begin
        base_q <= ring_base;
        log_q  <= ring_len_word[15:13];
      end
      if (st_q == ST_CFLG) begin
        flag_q <= mem_rdata[15:8];
        ahi_q  <= mem_rdata[7:0];
      end
      if (st_q == ST_ALO) alo_q <= mem_rdata;
      if (st_q == ST_BLAT) begin
        byte_q <= byte_pick(mem_rdata, cur_addr[0]);
        last_q <= final_byte;
      end
      if (st_q == ST_MACW && mac_done) begin
        mstat_q.retries  <= mac_retries;
        mstat_q.deferred <= mac_deferred;
        mstat_q.rtry     <= mac_rtry;
        mstat_q.lcar     <= mac_lcar;
        mstat_q.lcol     <= mac_lcol;
        mstat_q.uflo     <= mac_uflo;
        mstat_q.tdr      <= mac_tdr;
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    case (st_q)
      ST_RFLG:  begin mem_req = 1'b1; mem_addr = desc_addr | AW'(OFS_FLAG); end
      ST_RALO:  begin mem_req = 1'b1; mem_addr = desc_addr | AW'(OFS_ADDR_LO); end
      ST_ALO:   begin mem_req = 1'b1; mem_addr = desc_addr | AW'(OFS_LEN); end
      ST_BRD:   begin mem_req = 1'b1; mem_addr = cur_addr[BAW-1:1]; end
      ST_WSTAT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_addr | AW'(OFS_STAT); mem_wdata = stat_word;
      end
      ST_WFLG:  begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = desc_addr | AW'(OFS_FLAG); mem_wdata = {flag_out, ahi_q};
      end
      default: ;
    endcase
  end

  assign tx_valid = (st_q == ST_BOUT);
  assign tx_data  = byte_q;
  assign tx_last  = last_q;
  assign tint     = tint_q;

endmodule

// File: rtl/txd_ring_engine_chk.sv
module txd_ring_engine_chk #(
  parameter int unsigned IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             mem_req,
  input logic [15:0]      mem_wdata,
  input logic             tint,
  input logic             ev_stat_wr,
  input logic             ev_flag_wr,
  input logic             eng_idle,
  input logic [IDX_W-1:0] idx,
  input logic [IDX_W:0]   ring_size
);

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle && !cmd_start |=> !mem_req);                                   // R1

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !cmd_stop |=>
      tx_valid && $stable(tx_data) && $stable(tx_last));                    // R6

  AST_FLAG_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag_wr |-> $past(ev_stat_wr));                                      // R8

  AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag_wr |-> !mem_wdata[15]);                                         // R8

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag_wr |-> (mem_wdata[14] == (|($past(mem_wdata) & 16'hDC00))));     // R9

  AST_TINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tint |=> !tint);                                                        // R11

  AST_TINT_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tint |-> $past(ev_flag_wr));                                            // R11

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, idx} < ring_size);                                               // R12

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !tx_valid && !mem_req && !tint && (idx == '0));            // R13

endmodule

bind txd_ring_engine txd_ring_engine_chk #(.IDX_W(txd_pkg::IDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .cmd_stop   (cmd_stop),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .mem_req    (mem_req),
  .mem_wdata  (mem_wdata),
  .tint       (tint),
  .ev_stat_wr (ev_stat_wr),
  .ev_flag_wr (ev_flag_wr),
  .eng_idle   (eng_idle),
  .idx        (idx),
  .ring_size  (ring_size)
);

// File: tb/test_txd_ring_engine.sv
`timescale 1ns/1ps
module test_txd_ring_engine;

  localparam int unsigned AW = 23;
  localparam logic [11:0] BASE = 12'h010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_demand = 1'b0, poll_tick = 1'b0;
  logic [AW-1:0] ring_base = AW'(BASE);
  logic [15:0] ring_len_word = 16'h0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic tx_valid, tx_last, tint;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic mac_done = 1'b0;
  logic [1:0] mac_retries = 2'd0;
  logic mac_deferred = 1'b0, mac_rtry = 1'b0, mac_lcar = 1'b0, mac_lcol = 1'b0, mac_uflo = 1'b0;
  logic [9:0] mac_tdr = 10'h0;

  always #2.5 clk = ~clk;

  txd_ring_engine i_txd_ring_engine (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_demand(cmd_demand), .poll_tick(poll_tick), .ring_base(ring_base),
    .ring_len_word(ring_len_word), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .mac_done(mac_done), .mac_retries(mac_retries), .mac_deferred(mac_deferred),
    .mac_rtry(mac_rtry), .mac_lcar(mac_lcar), .mac_lcol(mac_lcol), .mac_uflo(mac_uflo),
    .mac_tdr(mac_tdr), .tint(tint)
  );

  // memory model: 4096 words, indexed by the low address bits
  logic [15:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  function automatic logic [15:0] pat(input logic [11:0] w);
    return {w[7:0] ^ 8'hA5, w[11:4] + 8'h3C};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [23:0] b);
    logic [15:0] w;
    w = pat(b[12:1]);
    return b[0] ? w[7:0] : w[15:8];
  endfunction

  // monitor / MAC model, all at the falling edge
  int n_chk = 0, n_fail = 0;
  int nbytes = 0, nlast = 0, last_pos = -1, nw = 0, nfr = 0, ntint = 0, hold_err = 0;
  int mac_cnt = 0;
  bit stall_en = 1'b0, prev_stalled = 1'b0;
  logic [7:0] prev_data = 8'h0;
  logic [7:0] lfsr = 8'h5B;
  logic [7:0]  rx_bytes [0:4095];
  logic [AW-1:0] wlog_addr [0:15];
  logic [15:0]   wlog_data [0:15];

  always @(negedge clk) begin
    if (stall_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = lfsr[0] & lfsr[2];
    end else begin
      tx_ready = 1'b1;
    end
    if (prev_stalled && (!tx_valid || tx_data != prev_data)) hold_err++;
    prev_stalled = tx_valid && !tx_ready;
    prev_data = tx_data;
    mac_done = 1'b0;
    if (mac_cnt != 0) begin
      mac_cnt--;
      if (mac_cnt == 0) mac_done = 1'b1;
    end
    if (tx_valid && tx_ready) begin
      if (nbytes < 4096) rx_bytes[nbytes] = tx_data;
      if (tx_last) begin nlast++; last_pos = nbytes; mac_cnt = 3; end
      nbytes++;
    end
    if (mem_req && mem_we) begin
      if (nw < 16) begin wlog_addr[nw] = mem_addr; wlog_data[nw] = mem_wdata; end
      nw++;
    end
    if (mem_req && !mem_we && mem_addr[1:0] == 2'b01) nfr++;
    if (tint) ntint++;
  end

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    nbytes = 0; nlast = 0; last_pos = -1; nw = 0; nfr = 0; ntint = 0; hold_err = 0;
  endtask

  task automatic set_desc(input int i, input logic [7:0] flag, input logic [23:0] baddr,
                          input logic [15:0] count);
    logic [11:0] a;
    a = BASE + 12'(4 * i);
    mem[a]     = baddr[15:0];
    mem[a + 1] = {flag, baddr[23:16]};
    mem[a + 2] = (~count + 16'd1) | 16'hF000;
    mem[a + 3] = 16'h0;
  endtask

  task automatic set_mac(input logic [1:0] r, input logic d, input logic rt, input logic lc,
                         input logic lo, input logic uf, input logic [9:0] tdr);
    mac_retries = r; mac_deferred = d; mac_rtry = rt; mac_lcar = lc;
    mac_lcol = lo; mac_uflo = uf; mac_tdr = tdr;
  endtask

  task automatic do_start(input logic [2:0] lg);
    ring_len_word = {lg, 13'h1ABC};
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic do_stop();
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
  endtask

  task automatic do_demand();
    cmd_demand = 1'b1; @(negedge clk); cmd_demand = 1'b0;
  endtask

  task automatic wait_tint(input int n);
    for (int k = 0; k < 20000 && ntint < n; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_bytes(input string req, input logic [23:0] start, input int count);
    int mism;
    mism = 0;
    for (int i = 0; i < count && i < 4096; i++)
      if (rx_bytes[i] != exp_byte(start + 24'(i))) mism++;
    chk_eq(req, "byte count", nbytes, count);
    chk_eq(req, "byte mismatches", mism, 0);
    chk_eq(req, "tx_last count", nlast, 1);
    chk_eq(req, "tx_last position", last_pos, count - 1);
  endtask

  task automatic t_reset();
    chk_eq("R1", "tx_valid after reset", tx_valid, 0);
    chk_eq("R1", "mem_req after reset", mem_req, 0);
    chk_eq("R1", "tint after reset", tint, 0);
    clear_log();
    do_demand();
    poll_tick = 1'b1; @(negedge clk); poll_tick = 1'b0;
    repeat (10) @(negedge clk);
    chk_eq("R1", "flag reads while idle", nfr, 0);
    chk_eq("R1", "writes while idle", nw, 0);
  endtask

  task automatic t_not_owned();
    set_desc(0, 8'h03, 24'h01_1000, 16'd10);
    do_start(3'd2);
    clear_log();
    do_demand();
    chk_eq("R2", "read request after demand", {mem_req, mem_we}, 2'b10);
    chk_eq("R2", "flag word address", mem_addr, AW'(BASE) + 1);
    repeat (20) @(negedge clk);
    chk_eq("R3", "bytes for host-owned entry", nbytes, 0);
    chk_eq("R3", "writes for host-owned entry", nw, 0);
    chk_eq("R3", "flag word untouched", mem[BASE + 1], 16'h0301);
    poll_tick = 1'b1; @(negedge clk); poll_tick = 1'b0;
    chk_eq("R3", "poll reads same entry", mem_addr, AW'(BASE) + 1);
    repeat (4) @(negedge clk);
    do_stop();
  endtask

  task automatic t_basic();
    set_desc(0, 8'h83, 24'h01_1000, 16'd7);
    set_mac(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h155);
    do_start(3'd2);
    clear_log();
    do_demand();
    wait_tint(1);
    chk_bytes("R5", 24'h01_1000, 7);
    chk_eq("R4", "count from length word", nbytes, 7);
    chk_eq("R7", "write count", nw, 2);
    chk_eq("R7", "status address", wlog_addr[0], AW'(BASE) + 3);
    chk_eq("R7", "status word", wlog_data[0], 16'h0155);
    chk_eq("R8", "flag address", wlog_addr[1], AW'(BASE) + 1);
    chk_eq("R8", "flag word", wlog_data[1], 16'h0301);
    chk_eq("R11", "tint pulses", ntint, 1);
    do_stop();
  endtask

  task automatic t_stall_odd();
    set_desc(0, 8'h83, 24'h01_1203, 16'd9);
    set_mac(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0);
    do_start(3'd2);
    clear_log();
    stall_en = 1'b1;
    do_demand();
    wait_tint(1);
    stall_en = 1'b0;
    chk_bytes("R5", 24'h01_1203, 9);
    chk_eq("R6", "byte changed while stalled", hold_err, 0);
    do_stop();
  endtask

  task automatic run_err(input string req, input logic [1:0] r, input logic d, input logic rt,
                         input logic lc, input logic lo, input logic uf, input logic [9:0] tdr,
                         input logic [15:0] exp_stat, input logic [7:0] exp_flag);
    set_desc(0, 8'h83, 24'h00_1100, 16'd3);
    set_mac(r, d, rt, lc, lo, uf, tdr);
    do_start(3'd2);
    clear_log();
    do_demand();
    wait_tint(1);
    chk_eq(req, "status word", wlog_data[0], exp_stat);
    chk_eq(req, "flag word", wlog_data[1], {exp_flag, 8'h00});
    do_stop();
  endtask

  task automatic t_errors();
    run_err("R9", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'h3FF, 16'h13FF, 8'h4F);
    run_err("R9", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 8'h13);
    run_err("R7", 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'h021, 16'h4C21, 8'h53);
    run_err("R8", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 8'h07);
  endtask

  task automatic t_no_end();
    set_desc(0, 8'h82, 24'h00_1301, 16'd1);
    set_mac(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0);
    do_start(3'd2);
    clear_log();
    do_demand();
    wait_tint(1);
    chk_bytes("R10", 24'h00_1301, 1);
    chk_eq("R10", "status with missing end", wlog_data[0], 16'h8000);
    chk_eq("R10", "flag with missing end", wlog_data[1], 16'h4200);
    do_stop();
  endtask

  task automatic t_wrap();
    set_desc(0, 8'h83, 24'h00_1000, 16'd3);
    set_desc(1, 8'h83, 24'h00_1100, 16'd4);
    set_mac(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0);
    do_start(3'd1);
    clear_log();
    do_demand();
    wait_tint(2);
    repeat (10) @(negedge clk);
    chk_eq("R12", "entries done on one demand", ntint, 2);
    chk_eq("R12", "bytes of both entries", nbytes, 7);
    chk_eq("R12", "second flag write address", wlog_addr[3], AW'(BASE) + 5);
    set_desc(0, 8'h83, 24'h00_1000, 16'd2);
    clear_log();
    do_demand();
    wait_tint(1);
    chk_eq("R12", "wrapped flag write address", wlog_addr[1], AW'(BASE) + 1);
    do_stop();
  endtask

  task automatic t_len_max();
    set_desc(0, 8'h83, 24'h00_1000, 16'd4096);
    set_mac(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0);
    do_start(3'd2);
    clear_log();
    do_demand();
    wait_tint(1);
    chk_eq("R4", "length word", mem[BASE + 2], 16'hF000);
    chk_bytes("R4", 24'h00_1000, 4096);
    do_stop();
  endtask

  task automatic t_stop();
    set_desc(0, 8'h83, 24'h00_1000, 16'd4);
    set_desc(1, 8'h83, 24'h00_1200, 16'd200);
    set_mac(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0);
    do_start(3'd2);
    clear_log();
    do_demand();
    for (int k = 0; k < 2000 && nbytes < 20; k++) @(negedge clk);
    do_stop();
    chk_eq("R13", "tx_valid after stop", tx_valid, 0);
    chk_eq("R13", "mem_req after stop", mem_req, 0);
    repeat (10) @(negedge clk);
    chk_eq("R13", "writes of stopped entry", nw, 2);
    chk_eq("R13", "stopped entry flag", mem[BASE + 5], 16'h8300);
    mem[BASE + 1] = 16'h0300;
    do_start(3'd2);
    do_demand();
    chk_eq("R13", "restart reads entry 0", mem_addr, AW'(BASE) + 1);
    repeat (4) @(negedge clk);
    do_stop();
  endtask

  bit done = 1'b0;

  initial begin
    for (int w = 0; w < 4096; w++) mem[w] = pat(12'(w));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_not_owned();
    t_basic();
    t_stall_odd();
    t_errors();
    t_no_end();
    t_wrap();
    t_len_max();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule